// File: doc/BRIEF.md
# Bus-Master DMA Channel Register File

This block holds the host-visible registers of a two-channel bus-master DMA engine for a disk controller. A host reaches them through a 16-byte I/O window with an address, a size code, write data and a combinational read-data bus. Each channel owns an 8-byte slot: a command byte, a status byte and a 32-bit descriptor-table pointer. The DMA engine beside it reads the start and direction controls from output pins. It reports activity, errors and interrupts through set inputs.

The status byte mixes three kinds of bit in one register:
- one bit owned by hardware that the host cannot write;
- two flags that the host clears by writing a one;
- two plain read/write capability bits.

Command and status accept byte accesses only. A wider read returns all ones for its width, and a wider write does nothing. The pointer register accepts byte, word and doubleword accesses at any lane, and it keeps its two low bits at zero.

Top module: `bmdma_regs`

## Requirements
- R1: Channel c occupies addresses 8c to 8c+7. Offset 0 is the command byte, offset 2 the status byte, and offsets 4 to 7 the descriptor pointer in little-endian byte order.
- R2: A byte read at offset 1 or 3 of a channel returns 0xFF. A write there changes no register.
- R3: Size codes are 0 for byte, 1 for word and 2 (or 3) for doubleword. On offsets 0 to 3, a non-byte read returns all ones for its width, zero-extended to 32 bits, and a non-byte write changes nothing.
- R4: A byte write to the command byte stores bit 0 (start) and bit 3 (direction), and the other command bits read 0. The start and direction bits of channel c drive startBit[c] and dirBit[c] from the clock edge that takes the write.
- R5: Status bit 0 (active) ignores host writes. It is set by actSet[c] and cleared by actClr[c] on the next clock edge.
- R6: Status bits 1 (error) and 2 (interrupt) are set by errSet[c] and intSet[c] and cleared by a status write carrying a one in that bit. When a set and a clear meet in the same cycle, the bit ends up set.
- R7: Status bits 5 and 6 take the written value on a status write. Bits 3, 4 and 7 always read 0.
- R8: The pointer takes byte, word or doubleword writes placed at the address lane and reads back shifted by the lane and masked to the width. Its bits 1:0 always read 0.
- R9: After reset every command, status and pointer register reads 0, and startBit and dirBit are 0.
- R10: An access or hardware input for one channel changes no register of the other channel.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ioAddr | input | 4 | Byte address in the window |
| ioSize | input | 2 | Access size code: 0 byte, 1 word, 2/3 doubleword |
| ioWr | input | 1 | Write strobe, taken on the rising edge |
| ioWrData | input | 32 | Write data, right-aligned |
| ioRdData | output | 32 | Read data for the current address and size, right-aligned |
| actSet | input | 2 | Per-channel set of status bit 0 |
| actClr | input | 2 | Per-channel clear of status bit 0 |
| errSet | input | 2 | Per-channel set of status bit 1 |
| intSet | input | 2 | Per-channel set of status bit 2 |
| startBit | output | 2 | Per-channel start control |
| dirBit | output | 2 | Per-channel direction control |

## Verification
The read path is combinational, so any wrong stored bit appears on ioRdData in the cycle after the edge that caused it, as soon as the bench addresses that register. The start and direction state also shows on the control pins one edge after a write. A lost set-over-clear priority shows as a zero error bit on the first read after a colliding cycle. A channel-decode fault shows as a register in the untouched channel that no longer reads its earlier value.

// File: rtl/bmdma_pkg.sv
package bmdma_pkg;
  localparam int DATA_W = 32;
  localparam int SLOT_BYTES = 8;

  typedef struct packed {
    logic       cmdWr;
    logic       statWr;
    logic [3:0] ptrBe;
  } chanStrobe_t;

  localparam logic [1:0] SZ_BYTE = 2'd0;
  localparam logic [1:0] SZ_WORD = 2'd1;
endpackage

// File: rtl/bmdma_ctrl.sv
module bmdma_ctrl
  import bmdma_pkg::*;
#(
  parameter int NCH = 2,
  parameter int AW  = $clog2(NCH * SLOT_BYTES)
) (
  input  logic [AW-1:0]     ioAddr,
  input  logic [1:0]        ioSize,
  input  logic              ioWr,
  output chanStrobe_t       strb [NCH],
  output logic [DATA_W-1:0] sizeMask
);
  logic [AW-1:0] chanIdx;
  logic [1:0]    lane;
  logic          isByte;
  logic [3:0]    laneBe;

  assign chanIdx = ioAddr >> 3;
  assign lane    = ioAddr[1:0];
  assign isByte  = (ioSize == SZ_BYTE);

  always_comb begin
    case (ioSize)
      SZ_BYTE: sizeMask = 32'h0000_00FF;
      SZ_WORD: sizeMask = 32'h0000_FFFF;
      default: sizeMask = 32'hFFFF_FFFF;
    endcase
  end

  always_comb begin
    case (ioSize)
      SZ_BYTE: laneBe = 4'b0001 << lane;
      SZ_WORD: laneBe = 4'b0011 << lane;
      default: laneBe = 4'b1111 << lane;
    endcase
  end

  for (genvar c = 0; c < NCH; c++) begin : g_strb
    always_comb begin
      strb[c] = '0;
      if (ioWr && (chanIdx == AW'(c))) begin
        if (!ioAddr[2]) begin
          strb[c].cmdWr  = isByte && (lane == 2'd0);
          strb[c].statWr = isByte && (lane == 2'd2);
        end else begin
          strb[c].ptrBe  = laneBe;
        end
      end
    end
  end
endmodule

// File: rtl/bmdma_datapath.sv
module bmdma_datapath
  import bmdma_pkg::*;
#(
  parameter int NCH = 2,
  parameter int AW  = $clog2(NCH * SLOT_BYTES)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [AW-1:0]     ioAddr,
  input  logic [1:0]        ioSize,
  input  logic [DATA_W-1:0] ioWrData,
  input  chanStrobe_t       strb [NCH],
  input  logic [DATA_W-1:0] sizeMask,
  input  logic [NCH-1:0]    actSet,
  input  logic [NCH-1:0]    actClr,
  input  logic [NCH-1:0]    errSet,
  input  logic [NCH-1:0]    intSet,
  output logic [DATA_W-1:0] ioRdData,
  output logic [NCH-1:0]    startBit,
  output logic [NCH-1:0]    dirBit
);
  logic [7:0]        cmdByte  [NCH];
  logic [7:0]        statByte [NCH];
  logic [DATA_W-1:0] ptrWord  [NCH];
  logic [DATA_W-1:0] laneData;
  logic [4:0]        laneShift;

  assign laneShift = {ioAddr[1:0], 3'b000};
  assign laneData  = ioWrData << laneShift;

  for (genvar c = 0; c < NCH; c++) begin : g_chan
    logic startQ, dirQ, actQ, errQ, intQ, cap5Q, cap6Q;
    logic [DATA_W-1:0] ptrQ;

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        startQ <= 1'b0;
        dirQ   <= 1'b0;
      end else if (strb[c].cmdWr) begin
        startQ <= ioWrData[0];
        dirQ   <= ioWrData[3];
      end
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        actQ  <= 1'b0;
        errQ  <= 1'b0;
        intQ  <= 1'b0;
        cap5Q <= 1'b0;
        cap6Q <= 1'b0;
      end else begin
        if (actSet[c])      actQ <= 1'b1;
        else if (actClr[c]) actQ <= 1'b0;
        errQ <= errSet[c] | (errQ & ~(strb[c].statWr & ioWrData[1]));
        intQ <= intSet[c] | (intQ & ~(strb[c].statWr & ioWrData[2]));
        if (strb[c].statWr) begin
          cap5Q <= ioWrData[5];
          cap6Q <= ioWrData[6];
        end
      end
    end

    for (genvar b = 0; b < 4; b++) begin : g_ptrLane
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                ptrQ[8*b +: 8] <= 8'h00;
        else if (strb[c].ptrBe[b]) ptrQ[8*b +: 8] <= laneData[8*b +: 8];
      end
    end

    assign cmdByte[c]  = {4'b0000, dirQ, 2'b00, startQ};
    assign statByte[c] = {1'b0, cap6Q, cap5Q, 2'b00, intQ, errQ, actQ};
    assign ptrWord[c]  = {ptrQ[DATA_W-1:2], 2'b00};
    assign startBit[c] = startQ;
    assign dirBit[c]   = dirQ;
  end

  always_comb begin
    ioRdData = '0;
    for (int c = 0; c < NCH; c++) begin
      if ((ioAddr >> 3) == AW'(c)) begin
        if (ioAddr[2]) begin
          ioRdData = (ptrWord[c] >> laneShift) & sizeMask;
        end else if (ioSize != SZ_BYTE) begin
          ioRdData = sizeMask;
        end else begin
          case (ioAddr[1:0])
            2'd0:    ioRdData = {24'h0, cmdByte[c]};
            2'd2:    ioRdData = {24'h0, statByte[c]};
            default: ioRdData = 32'h0000_00FF;
          endcase
        end
      end
    end
  end
endmodule

// File: rtl/bmdma_regs.sv
module bmdma_regs
  import bmdma_pkg::*;
#(
  parameter int NCH = 2,
  parameter int AW  = $clog2(NCH * SLOT_BYTES)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [AW-1:0]     ioAddr,
  input  logic [1:0]        ioSize,
  input  logic              ioWr,
  input  logic [DATA_W-1:0] ioWrData,
  output logic [DATA_W-1:0] ioRdData,
  input  logic [NCH-1:0]    actSet,
  input  logic [NCH-1:0]    actClr,
  input  logic [NCH-1:0]    errSet,
  input  logic [NCH-1:0]    intSet,
  output logic [NCH-1:0]    startBit,
  output logic [NCH-1:0]    dirBit
);
  chanStrobe_t       strb [NCH];
  logic [DATA_W-1:0] sizeMask;

  bmdma_ctrl #(.NCH(NCH), .AW(AW)) u_ctrl (
    .ioAddr(ioAddr), .ioSize(ioSize), .ioWr(ioWr),
    .strb(strb), .sizeMask(sizeMask)
  );

  bmdma_datapath #(.NCH(NCH), .AW(AW)) u_dp (
    .clk(clk), .rst_n(rst_n), .ioAddr(ioAddr), .ioSize(ioSize),
    .ioWrData(ioWrData), .strb(strb), .sizeMask(sizeMask),
    .actSet(actSet), .actClr(actClr), .errSet(errSet), .intSet(intSet),
    .ioRdData(ioRdData), .startBit(startBit), .dirBit(dirBit)
  );
endmodule

// File: rtl/bmdma_regs_checker.sv
module bmdma_regs_checker #(
  parameter int NCH = 2,
  parameter int AW  = 4
) (
  input logic           clk,
  input logic           rst_n,
  input logic [AW-1:0]  ioAddr,
  input logic [1:0]     ioSize,
  input logic           ioWr,
  input logic [31:0]    ioWrData,
  input logic [31:0]    ioRdData,
  input logic [NCH-1:0] errSet,
  input logic [NCH-1:0] startBit,
  input logic [NCH-1:0] dirBit
);
  p_pad_ff_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (ioSize == 2'd0 && !ioAddr[2] && ioAddr[0]) |-> ioRdData == 32'h0000_00FF);

  p_wide_ones_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (ioSize == 2'd1 && !ioAddr[2]) |-> ioRdData == 32'h0000_FFFF);

  p_wide_nowrite_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (ioWr && ioSize != 2'd0 && !ioAddr[2]) |=> ($stable(startBit) && $stable(dirBit)));

  p_cmd_store_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (ioWr && ioSize == 2'd0 && ioAddr == AW'(0)) |=> (startBit[0] == $past(ioWrData[0])));

  p_set_wins_r6: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(errSet[0]) && ioSize == 2'd0 && ioAddr == AW'(2)) |-> ioRdData[1]);

  p_ptr_align_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (ioSize == 2'd0 && ioAddr[2] && ioAddr[1:0] == 2'd0) |-> ioRdData[1:0] == 2'b00);
endmodule

bind bmdma_regs bmdma_regs_checker #(.NCH(NCH), .AW(AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .ioAddr(ioAddr), .ioSize(ioSize), .ioWr(ioWr),
  .ioWrData(ioWrData), .ioRdData(ioRdData), .errSet(errSet),
  .startBit(startBit), .dirBit(dirBit)
);

// File: tb/bmdma_regs_tb.sv
module bmdma_regs_tb;
  logic        clk = 0;
  logic        rst_n = 0;
  logic [3:0]  ioAddr = 0;
  logic [1:0]  ioSize = 0;
  logic        ioWr = 0;
  logic [31:0] ioWrData = 0;
  logic [31:0] ioRdData;
  logic [1:0]  actSet = 0, actClr = 0, errSet = 0, intSet = 0;
  logic [1:0]  startBit, dirBit;
  int checks = 0, errors = 0;

  always #5 clk = ~clk;

  bmdma_regs u_dut (
    .clk(clk), .rst_n(rst_n), .ioAddr(ioAddr), .ioSize(ioSize), .ioWr(ioWr),
    .ioWrData(ioWrData), .ioRdData(ioRdData), .actSet(actSet), .actClr(actClr),
    .errSet(errSet), .intSet(intSet), .startBit(startBit), .dirBit(dirBit)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
    end
  endtask

  task automatic wrIo(input logic [3:0] a, input logic [1:0] s, input logic [31:0] d);
    @(negedge clk);
    ioAddr = a; ioSize = s; ioWrData = d; ioWr = 1;
    @(negedge clk);
    ioWr = 0;
  endtask

  task automatic rdChk(input string req, input logic [3:0] a, input logic [1:0] s,
                       input logic [31:0] exp);
    @(negedge clk);
    ioAddr = a; ioSize = s; ioWr = 0;
    #1 check(req, ioRdData, exp);
  endtask

  task automatic hwPulse(input logic [1:0] aS, input logic [1:0] aC,
                         input logic [1:0] eS, input logic [1:0] iS);
    @(negedge clk);
    actSet = aS; actClr = aC; errSet = eS; intSet = iS;
    @(negedge clk);
    actSet = 0; actClr = 0; errSet = 0; intSet = 0;
  endtask

  task automatic testReset();
    rdChk("R9 ch0 cmd", 4'h0, 0, 32'h0);
    rdChk("R9 ch0 status", 4'h2, 0, 32'h0);
    rdChk("R9 ch1 ptr", 4'hC, 2, 32'h0);
    check("R9 startBit/dirBit", {28'h0, startBit, dirBit}, 32'h0);
  endtask

  task automatic testCommand();
    wrIo(4'h0, 0, 32'hFF);
    rdChk("R4 cmd readback", 4'h0, 0, 32'h09);
    check("R4 start/dir pins", {28'h0, startBit, dirBit}, 32'h5);
    rdChk("R10 ch1 cmd untouched", 4'h8, 0, 32'h0);
    wrIo(4'h8, 0, 32'h08);
    check("R1 ch1 dir only", {28'h0, startBit, dirBit}, 32'h7);
  endtask

  task automatic testPadAndWide();
    rdChk("R2 offset1", 4'h1, 0, 32'hFF);
    rdChk("R2 offset3", 4'hB, 0, 32'hFF);
    wrIo(4'h3, 0, 32'hFF);
    rdChk("R2 write ignored", 4'h2, 0, 32'h00);
    rdChk("R3 word read", 4'h0, 1, 32'h0000FFFF);
    rdChk("R3 dword read", 4'hA, 2, 32'hFFFFFFFF);
    wrIo(4'h0, 1, 32'h0);
    check("R3 word write ignored", {30'h0, startBit}, 32'h1);
    wrIo(4'h2, 2, 32'hFF);
    rdChk("R3 dword status write ignored", 4'h2, 0, 32'h00);
  endtask

  task automatic testStatus();
    wrIo(4'h2, 0, 32'hFF);
    rdChk("R7 caps written, others zero", 4'h2, 0, 32'h60);
    hwPulse(2'b01, 0, 0, 0);
    rdChk("R5 active set", 4'h2, 0, 32'h61);
    wrIo(4'h2, 0, 32'h00);
    rdChk("R5 active ignores write, R7 caps cleared", 4'h2, 0, 32'h01);
    hwPulse(0, 0, 2'b01, 2'b01);
    rdChk("R6 err/int set", 4'h2, 0, 32'h07);
    rdChk("R10 ch1 status untouched", 4'hA, 0, 32'h00);
    wrIo(4'h2, 0, 32'h02);
    rdChk("R6 w1c error", 4'h2, 0, 32'h05);
    @(negedge clk);
    ioAddr = 4'h2; ioSize = 0; ioWrData = 32'h06; ioWr = 1; errSet = 2'b01;
    @(negedge clk);
    ioWr = 0; errSet = 0;
    rdChk("R6 set wins over clear", 4'h2, 0, 32'h03);
    hwPulse(0, 2'b01, 0, 0);
    rdChk("R5 active cleared", 4'h2, 0, 32'h02);
  endtask

  task automatic testPointer();
    wrIo(4'hC, 2, 32'h12345677);
    rdChk("R8 dword low bits forced", 4'hC, 2, 32'h12345674);
    wrIo(4'hD, 0, 32'hAB);
    rdChk("R8 byte lane write", 4'hC, 2, 32'h1234AB74);
    rdChk("R8 word read upper", 4'hE, 1, 32'h00001234);
    rdChk("R8 byte read", 4'hC, 0, 32'h74);
    wrIo(4'hE, 1, 32'hBEEF);
    rdChk("R8 word lane write", 4'hC, 2, 32'hBEEFAB74);
    rdChk("R10 ch0 ptr untouched", 4'h4, 2, 32'h0);
  endtask

  initial begin
    fork
      begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        testReset();
        testCommand();
        testPadAndWide();
        testStatus();
        testPointer();
      end
      begin
        repeat (5000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    disable fork;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule